// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Refresh Scheduler

This block sits between a simple host port and a 4M-word by 4-bit asynchronous DRAM. The DRAM's row and column addresses share one 11-bit bus. The host makes single-word reads and writes through a valid/ready handshake and a flat 22-bit word address. The controller takes the upper half of that address as the row and the lower half as the column. It sequences the row strobe, the column strobe, the write enable and the shared address bus, using cycle-count timing parameters.

A built-in scheduler raises a refresh request once per row slot. The slot is the 32 ms retention window divided by the 2048 rows, worked out from the clock-frequency parameter. Requests that cannot be served at once are queued in a small saturating counter and then run back-to-back. By default the controller refreshes by bringing the column strobe down before the row strobe, so the memory supplies the row itself. A parameter selects a row-strobe-only scheme instead. In that scheme the column strobe stays high and an internal counter supplies the row.

After reset the controller keeps both strobes idle for a parameterised power-up interval. It then runs eight refresh cycles before it takes its first host request.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, both strobes and write enable are high (inactive), `req_ready` is 0 and `rd_valid` is 0.
- R2: For PWRUP_CYC cycles after reset the row strobe does not fall. Exactly eight refresh cycles then run before `req_ready` is first 1.
- R3: At the falling edge of the row strobe the address bus carries `req_addr[21:11]`. At the falling edge of the column strobe it carries `req_addr[10:0]`.
- R4: For a write, write enable is low and the data drive enable is 1 with `req_wdata` on the data output when the column strobe falls. For a read, write enable is high and the drive enable is 0 at that edge.
- R5: Read data is sampled while the column strobe is still low. It is returned on `rd_data` together with a `rd_valid` pulse that lasts exactly one cycle. Reading a word returns the value last written to it.
- R6: Row-to-column delay is at least T_RCD cycles. The column strobe stays low for at least T_CAS cycles during an access. The row strobe stays high for at least T_RP cycles before it falls again.
- R7: `req_ready` goes to 0 in the cycle after a request is accepted. It stays 0 until precharge ends. Each accepted request makes exactly one strobe cycle.
- R8: A refresh request is raised once every CLK_HZ/1000*32/2048 cycles, which is 781 cycles at the 50 MHz default.
- R9: A pending refresh is served before a waiting host request, so a host that streams requests without pause cannot starve refresh. An access that has started is always completed.
- R10: In the default mode (REF_MODE=0) the column strobe falls at least T_CSR cycles before the row strobe and stays low while the row strobe is low.
- R11: With REF_MODE=1 the column strobe stays high through every refresh. The row address comes from an internal counter that starts at 0 and steps by one (mod 2048) per refresh.
- R12: Queued refreshes, up to MAX_PEND of them, run back-to-back. In the default mode the column strobe stays low between chained refreshes while only the row strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Flat word address (row = upper 11 bits) |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | 4 | Data from memory |

## Verification
A refresh tick and a host request can land in the same cycle, and they then compete for the strobes. The bench provokes this by keeping the host stream full, write after read, for ten refresh periods, so every tick arrives while an access is running or while a request is waiting. It judges the result by checking the data of every read, by checking that the number of refresh cycles the memory model saw in that window matches the tick rate, and by checking that no strobe timing rule was broken. The power-up chain, in which eight queued refreshes run back-to-back before the first request is served, covers the queue-drain path.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    S_PWRUP, S_IDLE, S_ROW, S_COL, S_CBR_SET, S_REF_RAS, S_PRE
  } seq_st_t;

  localparam int REF_CBR      = 0;
  localparam int REF_RAS_ONLY = 1;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_CYC   = 781,
  parameter int MAX_PEND  = 8,
  parameter int INIT_REFS = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load_init,
  input  logic          take,
  output logic [PW-1:0] pend
);
  localparam int TW = $clog2(REF_CYC + 1);

  logic [TW-1:0] tmr;
  logic          tick;

  assign tick = run && (tmr == TW'(REF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  tmr <= '0;
    else if (tick)    tmr <= '0;
    else              tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else if (load_init) pend <= PW'(INIT_REFS);
    else begin
      case ({tick, take})
        2'b10: if (pend != PW'(MAX_PEND)) pend <= pend + 1'b1;
        2'b01: pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (rst)
    pend <= PW'(MAX_PEND)); // R12
  AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    take |-> (pend != '0)); // R9
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DQ_W      = 4,
  parameter int PWRUP_CYC = 10000,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 2,
  parameter int T_CSR     = 1,
  parameter int T_RAS_REF = 3,
  parameter int REF_MODE  = REF_CBR,
  parameter int PW        = 4,
  localparam int ROW_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [PW-1:0]     pend,
  output logic              run,
  output logic              load_init,
  output logic              take
);
  localparam int TM1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2 = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int TM3 = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMX = (TM3 > T_RAS_REF) ? TM3 : T_RAS_REF;
  localparam int CW  = $clog2(TMX + 1);
  localparam int PUW = $clog2(PWRUP_CYC + 1);

  seq_st_t          st;
  logic [CW-1:0]    cnt;
  logic [PUW-1:0]   pu_cnt;
  logic             chain;
  logic             op_we;
  logic [ROW_W-1:0] col_q;
  logic [ROW_W-1:0] ref_row;
  logic             cnt_done;
  logic             pu_done;

  assign cnt_done  = (cnt == '0);
  assign pu_done   = (pu_cnt == PUW'(PWRUP_CYC - 1));
  assign run       = (st != S_PWRUP);
  assign load_init = (st == S_PWRUP) && pu_done;
  assign req_ready = (st == S_IDLE) && (pend == '0);
  assign take      = ((st == S_IDLE) && (pend != '0)) ||
                     ((st == S_PRE) && cnt_done && chain);

  // Refresh row source: internal counter only in row-strobe-only mode
  generate
    if (REF_MODE == REF_RAS_ONLY) begin : g_ro_row
      always_ff @(posedge clk) begin
        if (rst) ref_row <= '0;
        else if (st == S_REF_RAS && cnt_done) ref_row <= ref_row + 1'b1;
      end
    end else begin : g_cbr_row
      assign ref_row = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_PWRUP; cnt <= '0; pu_cnt <= '0; chain <= 1'b0; op_we <= 1'b0;
      col_q <= '0; ras_n <= 1'b1; cas_n <= 1'b1; we_n <= 1'b1; addr <= '0;
      dq_o <= '0; dq_oe <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!cnt_done) cnt <= cnt - 1'b1;
      case (st)
        S_PWRUP: begin
          pu_cnt <= pu_cnt + 1'b1;
          if (pu_done) st <= S_IDLE;
        end
        S_IDLE: begin
          if (pend != '0) begin
            if (REF_MODE == REF_CBR) begin
              cas_n <= 1'b0; cnt <= CW'(T_CSR - 1); st <= S_CBR_SET;
            end else begin
              addr <= ref_row; ras_n <= 1'b0; cnt <= CW'(T_RAS_REF - 1);
              st <= S_REF_RAS;
            end
          end else if (req_valid) begin
            addr  <= req_addr[ADDR_W-1:ROW_W];
            col_q <= req_addr[ROW_W-1:0];
            op_we <= req_we;
            dq_o  <= req_wdata;
            ras_n <= 1'b0;
            cnt   <= CW'(T_RCD - 1);
            st    <= S_ROW;
          end
        end
        S_ROW: if (cnt_done) begin
          addr <= col_q; cas_n <= 1'b0; we_n <= !op_we; dq_oe <= op_we;
          cnt <= CW'(T_CAS - 1); st <= S_COL;
        end
        S_COL: if (cnt_done) begin
          if (!op_we) begin rd_data <= dq_i; rd_valid <= 1'b1; end
          cas_n <= 1'b1; ras_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0;
          cnt <= CW'(T_RP - 1); st <= S_PRE;
        end
        S_CBR_SET: if (cnt_done) begin
          ras_n <= 1'b0; cnt <= CW'(T_RAS_REF - 1); st <= S_REF_RAS;
        end
        S_REF_RAS: if (cnt_done) begin
          ras_n <= 1'b1;
          chain <= (pend != '0);
          if (pend == '0) cas_n <= 1'b1;
          cnt <= CW'(T_RP - 1); st <= S_PRE;
        end
        S_PRE: if (cnt_done) begin
          if (chain) begin
            chain <= 1'b0; ras_n <= 1'b0;
            if (REF_MODE == REF_RAS_ONLY) addr <= ref_row;
            cnt <= CW'(T_RAS_REF - 1); st <= S_REF_RAS;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == S_PWRUP) |-> (ras_n && cas_n)); // R2
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R7
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R5
  AST_CBR_LEAD: assert property (@(posedge clk) disable iff (rst)
    ((REF_MODE == REF_CBR) && $fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0)); // R10
  AST_RO_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((REF_MODE == REF_RAS_ONLY) && (st == S_REF_RAS)) |-> cas_n); // R11
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int REF_WINDOW_MS = 32,
  parameter int ADDR_W        = 22,
  parameter int DQ_W          = 4,
  parameter int PWRUP_CYC     = 10000,
  parameter int INIT_REFS     = 8,
  parameter int MAX_PEND      = 8,
  parameter int T_RCD         = 2,
  parameter int T_CAS         = 2,
  parameter int T_RP          = 2,
  parameter int T_CSR         = 1,
  parameter int T_RAS_REF     = 3,
  parameter int REF_MODE      = REF_CBR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DQ_W-1:0]       req_wdata,
  output logic                  rd_valid,
  output logic [DQ_W-1:0]       rd_data,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic [ADDR_W/2-1:0]   dram_addr,
  output logic [DQ_W-1:0]       dram_dq_o,
  output logic                  dram_dq_oe,
  input  logic [DQ_W-1:0]       dram_dq_i
);
  localparam int ROW_W   = ADDR_W / 2;
  localparam int ROWS    = 1 << ROW_W;
  localparam int REF_CYC = (CLK_HZ / 1000) * REF_WINDOW_MS / ROWS;
  localparam int PW      = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend;
  logic          run, load_init, take;

  dram_ref_timer #(
    .REF_CYC(REF_CYC), .MAX_PEND(MAX_PEND), .INIT_REFS(INIT_REFS)
  ) u_timer (
    .clk(clk), .rst(rst), .run(run), .load_init(load_init),
    .take(take), .pend(pend)
  );

  dram_seq #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .PWRUP_CYC(PWRUP_CYC),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR),
    .T_RAS_REF(T_RAS_REF), .REF_MODE(REF_MODE), .PW(PW)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ras_n(dram_ras_n),
    .cas_n(dram_cas_n), .we_n(dram_we_n), .addr(dram_addr),
    .dq_o(dram_dq_o), .dq_oe(dram_dq_oe), .dq_i(dram_dq_i),
    .pend(pend), .run(run), .load_init(load_init), .take(take)
  );
endmodule

// File: tb/dram_ctrl_tb.sv
module dram_model #(
  parameter int ROW_W = 11, DQ_W = 4,
  parameter int T_RCD = 2, T_CAS = 2, T_RP = 2, T_CSR = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DQ_W-1:0]  dq_o,
  input  logic             dq_oe,
  output logic [DQ_W-1:0]  dq_i
);
  logic [DQ_W-1:0] mem [int];
  int cyc, first_ras, ras_fall_cyc, ras_rise_cyc, cas_fall_cyc;
  int cbr_cnt, chain_cnt, ro_cnt, ro_seq_err, last_ro, acc_cnt;
  int viol_rcd, viol_cas, viol_rp, viol_csr;
  bit pr, pc, cas_in_ras, was_cbr, cas_rose;
  logic [ROW_W-1:0] row, col, last_row, last_col;
  bit last_we, last_oe;
  logic [DQ_W-1:0] last_wd;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; first_ras = -1; ras_fall_cyc = 0; ras_rise_cyc = -1; cas_fall_cyc = 0;
      cbr_cnt = 0; chain_cnt = 0; ro_cnt = 0; ro_seq_err = 0; last_ro = 0; acc_cnt = 0;
      viol_rcd = 0; viol_cas = 0; viol_rp = 0; viol_csr = 0;
      pr = 1; pc = 1; cas_in_ras = 0; was_cbr = 0; cas_rose = 1; dq_i = '0;
    end else begin
      cyc++;
      if (pr && !ras_n) begin
        if (first_ras < 0) first_ras = cyc;
        if (ras_rise_cyc >= 0 && cyc - ras_rise_cyc < T_RP) viol_rp++;
        ras_fall_cyc = cyc; cas_in_ras = 0;
        if (!cas_n) begin
          was_cbr = 1; cbr_cnt++;
          if (!cas_rose) chain_cnt++;
          else if (cyc - cas_fall_cyc < T_CSR) viol_csr++;
          cas_rose = 0;
        end else begin
          was_cbr = 0; row = addr;
        end
      end
      if (pc && !cas_n) begin
        cas_fall_cyc = cyc;
        if (!ras_n) begin
          cas_in_ras = 1; col = addr; acc_cnt++;
          if (cyc - ras_fall_cyc < T_RCD) viol_rcd++;
          last_we = !we_n; last_oe = dq_oe; last_row = row; last_col = col; last_wd = dq_o;
          if (!we_n) mem[int'({row, col})] = dq_o;
        end
      end
      if (!pc && cas_n) begin
        cas_rose = 1;
        if (cas_in_ras && !ras_n && cyc - cas_fall_cyc < T_CAS) viol_cas++;
        if (cas_in_ras && ras_n && cyc - cas_fall_cyc < T_CAS) viol_cas++;
      end
      if (!pr && ras_n) begin
        ras_rise_cyc = cyc;
        if (!was_cbr && !cas_in_ras) begin
          if (int'(row) != ((ro_cnt == 0) ? 0 : (last_ro + 1) % (1 << ROW_W))) ro_seq_err++;
          last_ro = int'(row); ro_cnt++;
        end
      end
      if (!ras_n && !cas_n && we_n && cas_in_ras)
        dq_i = mem.exists(int'({row, col})) ? mem[int'({row, col})] : '0;
      else dq_i = '0;
      pr = ras_n; pc = cas_n;
    end
  end
endmodule

module dram_ctrl_tb;
  localparam int PWRUP = 200;
  localparam int REFP  = 781;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_we = 0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data;
  logic        ras_n, cas_n, we_n, dq_oe;
  logic [10:0] maddr;
  logic [3:0]  dq_o, dq_i;

  logic        r_ready, r_rdv, r_ras, r_cas, r_we, r_oe;
  logic [3:0]  r_rdata, r_dqo, r_dqi;
  logic [10:0] r_addr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  dram_ctrl #(.PWRUP_CYC(PWRUP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(maddr),
    .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i));

  dram_model u_mem (.clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(maddr), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i));

  dram_ctrl #(.PWRUP_CYC(PWRUP), .REF_MODE(1)) u_dut_ro (
    .clk(clk), .rst(rst), .req_valid(1'b0), .req_ready(r_ready),
    .req_we(1'b0), .req_addr(22'd0), .req_wdata(4'd0),
    .rd_valid(r_rdv), .rd_data(r_rdata), .dram_ras_n(r_ras),
    .dram_cas_n(r_cas), .dram_we_n(r_we), .dram_addr(r_addr),
    .dram_dq_o(r_dqo), .dram_dq_oe(r_oe), .dram_dq_i(r_dqi));

  dram_model u_mem_ro (.clk(clk), .rst(rst), .ras_n(r_ras), .cas_n(r_cas),
    .we_n(r_we), .addr(r_addr), .dq_o(r_dqo), .dq_oe(r_oe), .dq_i(r_dqi));

  // {we, addr[21:0], data[3:0]}
  localparam logic [26:0] VEC [12] = '{
    {1'b1, 22'h000000, 4'hA}, {1'b1, 22'h3FFFFF, 4'h5},
    {1'b1, 22'h000800, 4'h3}, {1'b1, 22'h000001, 4'hC},
    {1'b1, 22'h2AA555, 4'h9}, {1'b0, 22'h000000, 4'hA},
    {1'b0, 22'h3FFFFF, 4'h5}, {1'b0, 22'h000800, 4'h3},
    {1'b0, 22'h000001, 4'hC}, {1'b0, 22'h2AA555, 4'h9},
    {1'b1, 22'h000000, 4'h6}, {1'b0, 22'h000000, 4'h6}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [21:0] a, input logic [3:0] d,
                        output logic [3:0] q, input bit verbose);
    int t;
    q = '0;
    @(negedge clk);
    t = 0;
    while (!req_ready && t < 200) begin @(negedge clk); t++; end
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (verbose) chk(!req_ready, "R7 ready low after accept", int'(req_ready), 0);
    if (!we) begin
      t = 0;
      while (!rd_valid && t < 50) begin @(negedge clk); t++; end
      q = rd_data;
      @(negedge clk);
      if (verbose) chk(!rd_valid, "R5 rd_valid single pulse", int'(rd_valid), 0);
    end
    t = 0;
    while (!req_ready && t < 200) begin @(negedge clk); t++; end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] q;
    int t, c0, start;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!req_ready && !rd_valid, "R1 ready/valid low in reset", {req_ready, rd_valid}, 0);
    rst = 0;
    @(negedge clk);
    chk(ras_n && cas_n && !req_ready, "R1 idle after reset", {ras_n, cas_n, req_ready}, 6);

    t = 0;
    while (!req_ready && t < 5000) begin @(negedge clk); t++; end
    chk(u_mem.first_ras >= PWRUP, "R2 quiet power-up", u_mem.first_ras, PWRUP);
    chk(u_mem.cbr_cnt == 8, "R2 eight init refreshes", u_mem.cbr_cnt, 8);
    chk(u_mem.chain_cnt == 7, "R12 chained refreshes keep CAS low", u_mem.chain_cnt, 7);
    chk(u_mem.viol_csr == 0, "R10 CAS leads RAS", u_mem.viol_csr, 0);

    foreach (VEC[i]) begin
      logic [26:0] v;
      v = VEC[i];
      do_req(v[26], v[25:4], v[3:0], q, 1'b1);
      chk(u_mem.last_row == v[25:15], "R3 row half", u_mem.last_row, v[25:15]);
      chk(u_mem.last_col == v[14:4], "R3 column half", u_mem.last_col, v[14:4]);
      chk(u_mem.last_we == v[26] && u_mem.last_oe == v[26], "R4 write enable/drive",
          {u_mem.last_we, u_mem.last_oe}, {v[26], v[26]});
      if (v[26]) chk(u_mem.last_wd == v[3:0], "R4 write data", u_mem.last_wd, v[3:0]);
      else       chk(q == v[3:0], "R5 read data", q, v[3:0]);
    end

    // Idle refresh rate
    c0 = u_mem.cbr_cnt; start = u_mem.cyc;
    repeat (REFP * 4) @(negedge clk);
    chk(u_mem.cbr_cnt - c0 >= 3 && u_mem.cbr_cnt - c0 <= 5, "R8 idle refresh rate",
        u_mem.cbr_cnt - c0, 4);

    // Saturated host traffic: refresh must still keep pace
    c0 = u_mem.cbr_cnt; start = u_mem.cyc;
    for (int k = 0; u_mem.cyc - start < REFP * 10; k++) begin
      logic [21:0] a;
      a = 22'(k * 4099 + 77);
      do_req(1'b1, a, 4'(k), q, 1'b0);
      do_req(1'b0, a, 4'(k), q, 1'b0);
      if (q != 4'(k)) chk(1'b0, "R9 read back under refresh load", q, 4'(k));
    end
    chk(u_mem.cbr_cnt - c0 >= 9 && u_mem.cbr_cnt - c0 <= 11, "R9 refresh not starved",
        u_mem.cbr_cnt - c0, 10);
    chk(u_mem.viol_rcd == 0, "R6 row-to-column delay", u_mem.viol_rcd, 0);
    chk(u_mem.viol_cas == 0, "R6 column strobe width", u_mem.viol_cas, 0);
    chk(u_mem.viol_rp == 0, "R6 precharge time", u_mem.viol_rp, 0);
    chk(u_mem.viol_csr == 0, "R10 CAS setup under load", u_mem.viol_csr, 0);

    chk(u_mem_ro.cbr_cnt == 0, "R11 no CAS in row-only refresh", u_mem_ro.cbr_cnt, 0);
    chk(u_mem_ro.ro_cnt >= 8, "R11 row-only refreshes ran", u_mem_ro.ro_cnt, 8);
    chk(u_mem_ro.ro_seq_err == 0, "R11 row counter steps by one", u_mem_ro.ro_seq_err, 0);
    chk(u_mem_ro.acc_cnt == 0 && !r_rdv, "R11 no access strobes", u_mem_ro.acc_cnt, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule